// File: doc/BRIEF.md
# Per-Gate Pending Event Filter

This block holds the future output changes of a single gate inside a hardware event-driven logic simulator. Each proposed change carries a time and a three-valued level. The block decides whether the change is worth keeping, inserts it into a short time-ordered list, and may cancel one pending entry that the new change makes redundant. When the gate has an inertial delay, it can also remove a pulse that would be shorter than that delay.

A retire strobe, together with the current simulation time, moves the earliest pending entry into the gate's present output level. Decisions and the updated list appear one clock after the request. When a retire and a proposal arrive in the same cycle, the retire is applied first and the proposal is judged against the shortened list.

Top module: `gate_event_filter`

## Requirements
- R1: While reset is asserted, and at the first sample after it, the list is empty, the output level is X (code 2'b10), and accept, cancel and overflow are 0.
- R2: If the list is empty, a proposal is inserted (accept=1) only when its level differs from the current output level.
- R3: A proposal whose time is at or after the last pending entry is inserted only when its level differs from that entry's level. A time equal to an entry's time places the proposal after that entry.
- R4: A proposal earlier than every pending entry is always kept. If the first entry has the same level, that entry's time is replaced by the new time (cancel=1, cancel_idx=0, count unchanged). Otherwise the proposal is inserted at the head.
- R5: A proposal that falls between two entries is kept only if its level differs from the entry before it. If the entry after it has the same level, that entry takes the new time and is reported cancelled at its index. Otherwise the proposal is inserted between the two entries.
- R6: A proposal in the R3 position that differs from the last entry, has the same level as the level before that entry, and lies less than INERTIAL time units after it, removes the last entry (cancel=1 at its index). The proposal itself is not inserted.
- R7: A proposal that must be inserted into a list already holding DEPTH entries raises overflow and is dropped. The list stays unchanged and accept and cancel remain 0.
- R8: A retire with now_time at or after the head entry's time pops that entry, and its level becomes the output level. A retire with an empty list, or with a head entry later than now_time, changes nothing. Without a retire, the output level holds. Entries stay in non-decreasing time order, and unused slots read as zero.
- R9: When a retire and a proposal occur in the same cycle, the proposal is judged against the list and output level left after the retire. A cancel index refers to that shortened list.
- R10: Levels are coded 2'b00 for 0, 2'b01 for 1 and 2'b10 for X. X counts as a distinct level in every comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Proposal present this cycle |
| ev_time | input | TW | Time of the proposed change |
| ev_val | input | 2 | Level of the proposed change |
| retire | input | 1 | Request to retire the head entry |
| now_time | input | TW | Current simulation time for retire |
| accept | output | 1 | Proposal was kept (inserted or replaced an entry) |
| cancel | output | 1 | A pending entry was removed or superseded |
| cancel_idx | output | clog2(DEPTH) | Index of the cancelled entry |
| overflow | output | 1 | Proposal needed a free slot and was dropped |
| out_val | output | 2 | Current output level of the gate |
| pend_count | output | clog2(DEPTH+1) | Number of pending entries |
| pend_time | output | DEPTH*TW | Entry times, entry 0 in the low bits |
| pend_val | output | DEPTH*2 | Entry levels, entry 0 in the low bits |

## Verification
A retire and a proposal can land in the same cycle, so the block has to shorten the list and judge the proposal against the shortened list within that one cycle. The bench provokes this by sweeping every proposal time and level against lists of zero to three entries, each with retire off, with retire at a time before the head, and with retire at the head's exact time. In the last case the output level changes under the proposal, and the expected decision, cancel index and resulting list are computed from the post-retire state.

// File: rtl/gate_event_filter.sv
module gate_event_filter #(
  parameter int TW = 8,
  parameter int DEPTH = 3,
  parameter int INERTIAL = 3,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ev_valid,
  input  logic [TW-1:0]         ev_time,
  input  logic [1:0]            ev_val,
  input  logic                  retire,
  input  logic [TW-1:0]         now_time,
  output logic                  accept,
  output logic                  cancel,
  output logic [IW-1:0]         cancel_idx,
  output logic                  overflow,
  output logic [1:0]            out_val,
  output logic [CW-1:0]         pend_count,
  output logic [DEPTH*TW-1:0]   pend_time,
  output logic [DEPTH*2-1:0]    pend_val
);

  localparam logic [TW-1:0] INR = TW'(INERTIAL);
  localparam logic [1:0] LVL_X = 2'b10;

  logic [TW-1:0] t_q [DEPTH];
  logic [TW-1:0] t_r [DEPTH];
  logic [TW-1:0] t_n [DEPTH];
  logic [1:0]    v_q [DEPTH];
  logic [1:0]    v_r [DEPTH];
  logic [1:0]    v_n [DEPTH];
  logic [CW-1:0] cnt_q, cnt_r, cnt_n, pos;
  logic [1:0]    cur_q, cur_r, prev_v, next_v, pre_last;
  logic [TW-1:0] last_t;
  logic          do_ret, want, kill, glitch, ins;

  // retire stage: pop the head if it is due
  assign do_ret = retire && (cnt_q != '0) && (t_q[0] <= now_time);
  assign cur_r  = do_ret ? v_q[0] : cur_q;
  assign cnt_r  = cnt_q - CW'(do_ret);

  for (genvar g = 0; g < DEPTH; g++) begin : g_pop
    if (g < DEPTH - 1) begin : g_mid
      assign t_r[g] = do_ret ? t_q[g+1] : t_q[g];
      assign v_r[g] = do_ret ? v_q[g+1] : v_q[g];
    end else begin : g_end
      assign t_r[g] = do_ret ? '0 : t_q[g];
      assign v_r[g] = do_ret ? '0 : v_q[g];
    end
    assign pend_time[g*TW +: TW] = t_q[g];
    assign pend_val[g*2 +: 2]    = v_q[g];
  end

  // locate the proposal and its neighbours
  always_comb begin
    pos = '0;
    prev_v = cur_r;
    next_v = LVL_X;
    pre_last = cur_r;
    last_t = '0;
    for (int i = 0; i < DEPTH; i++)
      if (CW'(i) < cnt_r && t_r[i] <= ev_time) pos = CW'(i + 1);
    for (int i = 0; i < DEPTH; i++) begin
      if (CW'(i + 1) == pos)   prev_v = v_r[i];
      if (CW'(i) == pos)       next_v = v_r[i];
      if (CW'(i + 1) == cnt_r) last_t = t_r[i];
    end
    for (int i = 0; i < DEPTH - 1; i++)
      if (CW'(i + 2) == cnt_r) pre_last = v_r[i];
  end

  // decide
  always_comb begin
    want = 1'b0;
    kill = 1'b0;
    glitch = 1'b0;
    if (ev_valid) begin
      if (cnt_r == '0) begin
        want = ev_val != cur_r;
      end else if (pos == '0) begin
        want = 1'b1;
        kill = next_v == ev_val;
      end else if (pos == cnt_r) begin
        if (ev_val != prev_v) begin
          if (ev_val == pre_last && (ev_time - last_t) < INR) glitch = 1'b1;
          else want = 1'b1;
        end
      end else if (ev_val != prev_v) begin
        want = 1'b1;
        kill = next_v == ev_val;
      end
    end
  end

  assign ins = want && (kill || cnt_r != CW'(DEPTH));

  // build the next list
  always_comb begin
    cnt_n = cnt_r;
    for (int i = 0; i < DEPTH; i++) begin
      t_n[i] = t_r[i];
      v_n[i] = v_r[i];
    end
    if (ins && kill) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == pos) t_n[i] = ev_time;
    end else if (ins) begin
      for (int i = 1; i < DEPTH; i++)
        if (CW'(i) > pos) begin
          t_n[i] = t_r[i-1];
          v_n[i] = v_r[i-1];
        end
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i) == pos) begin
          t_n[i] = ev_time;
          v_n[i] = ev_val;
        end
      cnt_n = cnt_r + 1'b1;
    end else if (glitch) begin
      for (int i = 0; i < DEPTH; i++)
        if (CW'(i + 1) == cnt_r) begin
          t_n[i] = '0;
          v_n[i] = '0;
        end
      cnt_n = cnt_r - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) begin
        t_q[i] <= '0;
        v_q[i] <= '0;
      end
      cnt_q      <= '0;
      cur_q      <= LVL_X;
      accept     <= 1'b0;
      cancel     <= 1'b0;
      cancel_idx <= '0;
      overflow   <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        t_q[i] <= t_n[i];
        v_q[i] <= v_n[i];
      end
      cnt_q      <= cnt_n;
      cur_q      <= cur_r;
      accept     <= ins;
      cancel     <= (ins && kill) || glitch;
      cancel_idx <= glitch ? IW'(cnt_r - 1'b1) : IW'(pos);
      overflow   <= want && !ins;
    end
  end

  assign out_val = cur_q;
  assign pend_count = cnt_q;

endmodule

// File: rtl/gate_event_filter_chk.sv
module gate_event_filter_chk #(
  parameter int TW = 8,
  parameter int DEPTH = 3,
  localparam int CW = $clog2(DEPTH + 1),
  localparam int IW = $clog2(DEPTH)
) (
  input logic                clk,
  input logic                rst_n,
  input logic                retire,
  input logic                accept,
  input logic                cancel,
  input logic [IW-1:0]       cancel_idx,
  input logic                overflow,
  input logic [1:0]          out_val,
  input logic [CW-1:0]       pend_count,
  input logic [DEPTH*TW-1:0] pend_time
);

  a_r7_overflow_full: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> (!accept && !cancel && pend_count == CW'(DEPTH)));

  a_r4_cancel_index: assert property (@(posedge clk) disable iff (!rst_n)
    cancel |-> (int'(cancel_idx) <= int'(pend_count)));

  a_r3_accept_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
    accept |-> (pend_count != '0));

  a_r8_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !retire |=> $stable(out_val));

  for (genvar g = 0; g < DEPTH - 1; g++) begin : g_ord
    a_r8_sorted: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_count > CW'(g + 1)) |-> (pend_time[g*TW +: TW] <= pend_time[(g+1)*TW +: TW]));
  end

endmodule

bind gate_event_filter gate_event_filter_chk #(.TW(TW), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .retire(retire), .accept(accept), .cancel(cancel),
  .cancel_idx(cancel_idx), .overflow(overflow), .out_val(out_val),
  .pend_count(pend_count), .pend_time(pend_time)
);

// File: tb/gate_event_filter_test.sv
module gate_event_filter_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ev_valid = 1'b0;
  logic [7:0] ev_time = '0;
  logic [1:0] ev_val = '0;
  logic       retire = 1'b0;
  logic [7:0] now_time = '0;
  logic       accept, cancel, overflow;
  logic [1:0] cancel_idx, out_val, pend_count;
  logic [23:0] pend_time;
  logic [5:0]  pend_val;

  int checks = 0;
  int errors = 0;

  int mt[3], mv[3], mc, mcur, eci;
  bit ea, ec, eo;

  always #10 clk = ~clk;

  gate_event_filter #(.TW(8), .DEPTH(3), .INERTIAL(3)) uut (
    .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_time(ev_time), .ev_val(ev_val),
    .retire(retire), .now_time(now_time), .accept(accept), .cancel(cancel),
    .cancel_idx(cancel_idx), .overflow(overflow), .out_val(out_val),
    .pend_count(pend_count), .pend_time(pend_time), .pend_val(pend_val)
  );

  task automatic check(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic model(input bit val, input int t, input int v, input bit ret,
                       input int now, output string tag);
    bit popped, doins;
    int p, bl;
    popped = 0; doins = 0; ea = 0; ec = 0; eo = 0; eci = 0;
    tag = "R8";
    if (ret && mc > 0 && mt[0] <= now) begin
      mcur = mv[0];
      for (int i = 0; i < 2; i++) begin mt[i] = mt[i+1]; mv[i] = mv[i+1]; end
      mt[2] = 0; mv[2] = 0; mc--; popped = 1;
    end
    if (val) begin
      p = 0;
      for (int i = 0; i < mc; i++) if (mt[i] <= t) p = i + 1;
      if (mc == 0) begin
        tag = "R2";
        doins = (v != mcur);
      end else if (p == 0) begin
        tag = "R4";
        if (mv[0] == v) begin mt[0] = t; ec = 1; eci = 0; ea = 1; end
        else doins = 1;
      end else if (p == mc) begin
        tag = "R3";
        if (v != mv[mc-1]) begin
          bl = (mc >= 2) ? mv[mc-2] : mcur;
          if (v == bl && t - mt[mc-1] < 3) begin
            tag = "R6"; ec = 1; eci = mc - 1;
            mt[mc-1] = 0; mv[mc-1] = 0; mc--;
          end else doins = 1;
        end
      end else begin
        tag = "R5";
        if (v != mv[p-1]) begin
          if (mv[p] == v) begin mt[p] = t; ec = 1; eci = p; ea = 1; end
          else doins = 1;
        end
      end
      if (doins) begin
        if (mc == 3) begin eo = 1; tag = "R7"; end
        else begin
          for (int i = 2; i > p; i--) begin mt[i] = mt[i-1]; mv[i] = mv[i-1]; end
          mt[p] = t; mv[p] = v; mc++; ea = 1;
        end
      end
      if (popped) tag = "R9";
    end
  endtask

  task automatic do_reset;
    @(negedge clk);
    rst_n = 1'b0; ev_valid = 1'b0; retire = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin mt[i] = 0; mv[i] = 0; end
    mc = 0; mcur = 2;
  endtask

  task automatic step(input bit val, input int t, input int v, input bit ret, input int now);
    string tag;
    logic [63:0] got, exp;
    ev_valid = val; ev_time = 8'(t); ev_val = 2'(v); retire = ret; now_time = 8'(now);
    model(val, t, v, ret, now, tag);
    @(negedge clk);
    got = {25'd0, accept, cancel, (cancel ? cancel_idx : 2'b00), overflow, out_val,
           pend_count, pend_time, pend_val};
    exp = {25'd0, ea, ec, (ec ? 2'(eci) : 2'b00), eo, 2'(mcur), 2'(mc),
           8'(mt[2]), 8'(mt[1]), 8'(mt[0]), 2'(mv[2]), 2'(mv[1]), 2'(mv[0])};
    check(tag, got, exp);
    ev_valid = 1'b0; retire = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int sv[2][3];
    sv[0] = '{1, 0, 1};
    sv[1] = '{0, 2, 1};

    // R1: reset state, sampled during reset and just after release
    @(negedge clk);
    check("R1", {accept, cancel, overflow, out_val, pend_count}, {3'b000, 2'b10, 2'b00});
    do_reset;
    check("R1", {accept, cancel, overflow, out_val, pend_count, pend_time, pend_val},
          {3'b000, 2'b10, 2'b00, 24'd0, 6'd0});

    // R10: X is its own level
    step(1, 3, 2, 0, 0);
    check("R10", {63'd0, accept}, 64'd0);
    step(1, 3, 0, 0, 0);
    check("R10", {63'd0, accept}, 64'd1);
    step(1, 9, 2, 0, 0);
    check("R10", {62'd0, accept, cancel}, 64'd2);

    // R8: retire of an empty list leaves the level at X
    do_reset;
    step(0, 0, 0, 1, 200);

    // sweep: list contents x list length x retire mode x time x level
    for (int s = 0; s < 2; s++)
      for (int k = 0; k < 4; k++)
        for (int r = 0; r < 3; r++)
          for (int t = 0; t < 16; t++)
            for (int v = 0; v < 3; v++) begin
              do_reset;
              for (int e = 0; e < k; e++) step(1, 4 * (e + 1), sv[s][e], 0, 0);
              step(1, t, v, r != 0, (r == 2) ? 4 : 3);
            end

    // R8: retire-only pops in time order until empty
    do_reset;
    step(1, 4, 1, 0, 0);
    step(1, 8, 0, 0, 0);
    step(0, 0, 0, 1, 7);
    step(0, 0, 0, 1, 7);
    step(0, 0, 0, 1, 8);
    step(0, 0, 0, 1, 9);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule